// File: doc/BRIEF.md
# Smart Card Session Tracker

This block follows a single contact-card session without ever driving the line. It watches the card reset level and a stream of already-deserialised characters and keeps the session phase: held in reset, waiting for the answer-to-reset, inside the answer-to-reset, waiting for a command, inside a command, or inside a protocol-parameter-selection (PPS) exchange. It steers each accepted character to the answer-to-reset parser or to the PPS parser through two routing enables. Those parsers report back through completion strobes and through parameter-update strobes.

The block holds the clock-rate index, the baud-divisor index and the waiting-integer value for the session. It owns a character waiting-time counter that advances once per elementary time unit (ETU). The counter's limit starts at a fixed initial value. When the answer-to-reset finishes, the limit is recomputed from the parameters the parsers have reported. An expired waiting time, or any change on the reset line, raises a one-cycle flush pulse that tells a downstream capture buffer a frame has ended. Two saturating counters record reset releases and PPS exchanges.

Top module: `sc_session_tracker`

## Requirements
- R1: While the phase is reset (code 0) and the reset line stays low, the phase does not change. Received bytes produce no routing enable, and the parameter-update strobes leave fi, di and wi unchanged.
- R2: A rise of the reset line moves the phase to wait-for-answer (code 1). It loads fi=1, di=1 and wi=10, sets the waiting limit to INIT_WT (9600), and increments the reset-event counter.
- R3: In phase 1 or in-answer (code 2), an accepted byte raises the answer routing enable in its own cycle. The first such byte moves phase 1 to phase 2.
- R4: In wait-for-command (code 3), byte 0xFF raises the PPS routing enable, moves to in-PPS (code 5) and increments the PPS counter. Any other byte moves to in-command (code 4) without routing.
- R5: In phase 5, every byte raises the PPS routing enable. A pps_done strobe returns the phase to 3.
- R6: An atr_done strobe in phase 2 moves to phase 3 and sets the limit to 960 × D × wi. D depends on the di index: indexes 1 to 7 give 2^(di−1), 8 gives 12, 9 gives 20, and every other index gives 1.
- R7: Outside phase 0, wi_upd loads wi from wi_in. fidi_upd loads fi from fidi_in[7:4] and di from fidi_in[3:0].
- R8: The waiting counter restarts on every accepted byte and on every phase event. When L ETU ticks have passed since the restart (L being the limit), the block gives exactly one flush pulse and moves to phase 3 from any non-reset phase. It gives no further pulse until the counter restarts.
- R9: A change of the reset line in either direction gives a flush pulse in the cycle after the change is sampled. The phase changes one cycle after that.
- R10: Both event counters stop at 2^CNT_W − 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| card_rst_n | input | 1 | Card reset line level, already synchronised |
| rx_valid | input | 1 | Received-character strobe |
| rx_data | input | 8 | Received character |
| etu_tick | input | 1 | One pulse per ETU |
| wi_upd | input | 1 | Load waiting integer from wi_in |
| wi_in | input | 8 | Waiting integer reported by the answer parser |
| fidi_upd | input | 1 | Load fi/di indexes from fidi_in |
| fidi_in | input | 8 | Fi index in the high nibble, Di index in the low nibble |
| atr_done | input | 1 | Answer parser reports completion |
| pps_done | input | 1 | PPS parser reports completion |
| phase_o | output | 3 | Session phase code |
| flush_o | output | 1 | One-cycle end-of-frame pulse |
| wt_limit_o | output | WT_W | Current waiting limit in ETUs |
| atr_route_o | output | 1 | Current byte belongs to the answer parser |
| pps_route_o | output | 1 | Current byte belongs to the PPS parser |
| fi_idx_o | output | 4 | Held clock-rate index |
| di_idx_o | output | 4 | Held baud-divisor index |
| wi_o | output | 8 | Held waiting integer |
| rst_events_o | output | CNT_W | Saturating count of reset releases |
| pps_events_o | output | CNT_W | Saturating count of PPS exchanges |

## Verification
The bench builds the tracker with CNT_W=3 and keeps the default waiting-time constants. With CNT_W=3, both counters reach saturation after a handful of sessions. The bench sweeps all sixteen di indexes against three waiting integers and computes each resulting limit arithmetically. It measures the expiry at full scale: 9600 ticks after reset release and 960 ticks after a short answer, counted tick by tick from the restarting byte.

// File: rtl/sc_trk_pkg.sv
package sc_trk_pkg;

    typedef enum logic [2:0] {
        PH_RESET    = 3'd0,
        PH_WAIT_ATR = 3'd1,
        PH_IN_ATR   = 3'd2,
        PH_WAIT_CMD = 3'd3,
        PH_IN_CMD   = 3'd4,
        PH_IN_PPS   = 3'd5
    } phase_e;

    typedef struct packed {
        logic [3:0] fi;
        logic [3:0] di;
        logic [7:0] wi;
    } tparam_t;

    localparam logic [7:0] PPS_START = 8'hFF;
    localparam tparam_t    TPARAM_DEFAULT = '{fi: 4'd1, di: 4'd1, wi: 8'd10};

    // Baud-rate adjustment factor for a di index; reserved indexes map to 1.
    function automatic logic [6:0] d_factor(input logic [3:0] idx);
        logic [6:0] f;
        case (idx)
            4'd1:    f = 7'd1;
            4'd2:    f = 7'd2;
            4'd3:    f = 7'd4;
            4'd4:    f = 7'd8;
            4'd5:    f = 7'd16;
            4'd6:    f = 7'd32;
            4'd7:    f = 7'd64;
            4'd8:    f = 7'd12;
            4'd9:    f = 7'd20;
            default: f = 7'd1;
        endcase
        return f;
    endfunction

endpackage

// File: rtl/sc_wt_timer.sv
module sc_wt_timer #(
    parameter int WT_W = 24
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            en,
    input  logic            clr,
    input  logic            tick,
    input  logic [WT_W-1:0] limit,
    output logic            hit
);
    logic [WT_W-1:0] cnt_q;
    logic            armed_q;
    logic [WT_W:0]   cnt_nxt;

    always_comb begin
        cnt_nxt = {1'b0, cnt_q} + 1'b1;
        hit     = en && tick && armed_q && !clr && (cnt_nxt >= {1'b0, limit});
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            armed_q <= 1'b0;
        end else if (clr) begin
            cnt_q   <= '0;
            armed_q <= 1'b1;
        end else if (en && tick && armed_q) begin
            cnt_q <= cnt_nxt[WT_W-1:0];
            if (hit) armed_q <= 1'b0;
        end
    end

    AST_EXPIRE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        hit |=> !hit);                                            // R8
    AST_DISARMED_AFTER_HIT: assert property (@(posedge clk) disable iff (rst)
        (hit && !clr) |=> !armed_q || clr);                       // R8

endmodule

// File: rtl/sc_sat_ctr.sv
module sc_sat_ctr #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] TOP = '1;

    always_ff @(posedge clk) begin
        if (rst)                    cnt <= '0;
        else if (inc && cnt != TOP) cnt <= cnt + 1'b1;
    end

    AST_SAT_STICKY: assert property (@(posedge clk) disable iff (rst)
        (cnt == TOP) |=> (cnt == TOP));                           // R10
    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
        !inc |=> $stable(cnt));                                   // R10

endmodule

// File: rtl/sc_session_tracker.sv
module sc_session_tracker
    import sc_trk_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int WT_W    = 24,
    parameter int INIT_WT = 9600,
    parameter int WT_MULT = 960
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             card_rst_n,
    input  logic             rx_valid,
    input  logic [7:0]       rx_data,
    input  logic             etu_tick,
    input  logic             wi_upd,
    input  logic [7:0]       wi_in,
    input  logic             fidi_upd,
    input  logic [7:0]       fidi_in,
    input  logic             atr_done,
    input  logic             pps_done,
    output logic [2:0]       phase_o,
    output logic             flush_o,
    output logic [WT_W-1:0]  wt_limit_o,
    output logic             atr_route_o,
    output logic             pps_route_o,
    output logic [3:0]       fi_idx_o,
    output logic [3:0]       di_idx_o,
    output logic [7:0]       wi_o,
    output logic [CNT_W-1:0] rst_events_o,
    output logic [CNT_W-1:0] pps_events_o
);
    localparam int N_EV  = 2;
    localparam int EV_RST = 0;
    localparam int EV_PPS = 1;
    localparam logic [WT_W-1:0] INIT_LIMIT = WT_W'(INIT_WT);

    logic            rst_q, rst_qq;
    logic            line_chg, apply;
    phase_e          ph_q, ph_d;
    tparam_t         par_q, par_d;
    logic [WT_W-1:0] lim_q, lim_d;
    logic            flush_q;
    logic            active, byte_ok;
    logic            wt_clr, wt_hit;
    logic [31:0]     atr_prod;
    logic [N_EV-1:0] ev_inc;
    logic [CNT_W-1:0] ev_cnt [N_EV];

    // Reset-line edge pipeline: first stage flags a flush, second applies it.
    assign line_chg = card_rst_n ^ rst_q;
    assign apply    = rst_q ^ rst_qq;
    assign active   = (ph_q != PH_RESET);
    assign byte_ok  = rx_valid && active && !apply;

    assign atr_route_o = byte_ok && (ph_q == PH_WAIT_ATR || ph_q == PH_IN_ATR);
    assign pps_route_o = byte_ok && ((ph_q == PH_WAIT_CMD && rx_data == PPS_START)
                                     || ph_q == PH_IN_PPS);

    assign atr_prod = 32'(WT_MULT) * 32'(d_factor(par_q.di)) * 32'(par_q.wi);

    always_comb begin
        ph_d   = ph_q;
        par_d  = par_q;
        lim_d  = lim_q;
        wt_clr = 1'b0;
        ev_inc = '0;
        if (active && !apply) begin
            if (wi_upd)   par_d.wi = wi_in;
            if (fidi_upd) {par_d.fi, par_d.di} = fidi_in;
        end
        if (apply) begin
            wt_clr = 1'b1;
            if (rst_q) begin
                ph_d           = PH_WAIT_ATR;
                par_d          = TPARAM_DEFAULT;
                lim_d          = INIT_LIMIT;
                ev_inc[EV_RST] = 1'b1;
            end else begin
                ph_d = PH_RESET;
            end
        end else if (!active) begin
            ph_d = PH_RESET;
        end else if (rx_valid) begin
            wt_clr = 1'b1;
            case (ph_q)
                PH_WAIT_ATR: ph_d = PH_IN_ATR;
                PH_WAIT_CMD: begin
                    if (rx_data == PPS_START) begin
                        ph_d           = PH_IN_PPS;
                        ev_inc[EV_PPS] = 1'b1;
                    end else begin
                        ph_d = PH_IN_CMD;
                    end
                end
                default: ph_d = ph_q;
            endcase
        end else if (atr_done && ph_q == PH_IN_ATR) begin
            wt_clr = 1'b1;
            ph_d   = PH_WAIT_CMD;
            lim_d  = atr_prod[WT_W-1:0];
        end else if (pps_done && ph_q == PH_IN_PPS) begin
            wt_clr = 1'b1;
            ph_d   = PH_WAIT_CMD;
        end else if (wt_hit) begin
            ph_d = PH_WAIT_CMD;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rst_q   <= 1'b0;
            rst_qq  <= 1'b0;
            ph_q    <= PH_RESET;
            par_q   <= TPARAM_DEFAULT;
            lim_q   <= INIT_LIMIT;
            flush_q <= 1'b0;
        end else begin
            rst_q   <= card_rst_n;
            rst_qq  <= rst_q;
            ph_q    <= ph_d;
            par_q   <= par_d;
            lim_q   <= lim_d;
            flush_q <= line_chg || wt_hit;
        end
    end

    sc_wt_timer #(.WT_W(WT_W)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .en    (active),
        .clr   (wt_clr),
        .tick  (etu_tick),
        .limit (lim_q),
        .hit   (wt_hit)
    );

    for (genvar g = 0; g < N_EV; g++) begin : g_ev
        sc_sat_ctr #(.W(CNT_W)) u_ctr (
            .clk (clk),
            .rst (rst),
            .inc (ev_inc[g]),
            .cnt (ev_cnt[g])
        );
    end

    assign phase_o      = ph_q;
    assign flush_o      = flush_q;
    assign wt_limit_o   = lim_q;
    assign fi_idx_o     = par_q.fi;
    assign di_idx_o     = par_q.di;
    assign wi_o         = par_q.wi;
    assign rst_events_o = ev_cnt[EV_RST];
    assign pps_events_o = ev_cnt[EV_PPS];

    AST_RESET_STAYS: assert property (@(posedge clk) disable iff (rst)
        (ph_q == PH_RESET && !rst_q) |=> (ph_q == PH_RESET));             // R1
    AST_RISE_DEFAULTS: assert property (@(posedge clk) disable iff (rst)
        (apply && rst_q) |=> (ph_q == PH_WAIT_ATR && lim_q == INIT_LIMIT)); // R2
    AST_ATR_ENTRY: assert property (@(posedge clk) disable iff (rst)
        (atr_route_o && ph_q == PH_WAIT_ATR) |=> (ph_q == PH_IN_ATR));    // R3
    AST_PPS_ENTRY: assert property (@(posedge clk) disable iff (rst)
        (pps_route_o && ph_q == PH_WAIT_CMD) |=> (ph_q == PH_IN_PPS));    // R4
    AST_EXPIRY_PHASE: assert property (@(posedge clk) disable iff (rst)
        wt_hit |=> (ph_q == PH_WAIT_CMD && flush_o));                     // R8
    AST_FLUSH_ON_LINE: assert property (@(posedge clk) disable iff (rst)
        line_chg |=> flush_o);                                            // R9

endmodule

// File: tb/sim_sc_session_tracker.sv
`timescale 1ns/100ps
module sim_sc_session_tracker;
    localparam int CNT_W = 3;
    localparam int WT_W  = 24;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic card_rst_n = 1'b0, rx_valid = 1'b0, etu_tick = 1'b1;
    logic [7:0] rx_data = 8'h00, wi_in = 8'h00, fidi_in = 8'h00;
    logic wi_upd = 1'b0, fidi_upd = 1'b0, atr_done = 1'b0, pps_done = 1'b0;
    logic [2:0] phase_o;
    logic flush_o, atr_route_o, pps_route_o;
    logic [WT_W-1:0] wt_limit_o;
    logic [3:0] fi_idx_o, di_idx_o;
    logic [7:0] wi_o;
    logic [CNT_W-1:0] rst_events_o, pps_events_o;

    int vectors = 0;
    int fails = 0;
    bit ended = 1'b0;

    always #2.5 clk = ~clk;

    sc_session_tracker #(.CNT_W(CNT_W), .WT_W(WT_W)) u0 (
        .clk(clk), .rst(rst), .card_rst_n(card_rst_n), .rx_valid(rx_valid),
        .rx_data(rx_data), .etu_tick(etu_tick), .wi_upd(wi_upd), .wi_in(wi_in),
        .fidi_upd(fidi_upd), .fidi_in(fidi_in), .atr_done(atr_done),
        .pps_done(pps_done), .phase_o(phase_o), .flush_o(flush_o),
        .wt_limit_o(wt_limit_o), .atr_route_o(atr_route_o),
        .pps_route_o(pps_route_o), .fi_idx_o(fi_idx_o), .di_idx_o(di_idx_o),
        .wi_o(wi_o), .rst_events_o(rst_events_o), .pps_events_o(pps_events_o)
    );

    task automatic check(input string tag, input longint act, input longint exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int d_exp(input int idx);
        if (idx >= 1 && idx <= 7) return 1 << (idx - 1);
        if (idx == 8) return 12;
        if (idx == 9) return 20;
        return 1;
    endfunction

    task automatic line(input logic v, input int ph_before, input int ph_after);
        @(negedge clk) card_rst_n = v;
        @(posedge clk); #1;
        check("R9 flush after line change", flush_o, 1);
        check("R9 phase held one cycle", phase_o, ph_before);
        @(posedge clk); #1;
        check("R9 phase after line change", phase_o, ph_after);
        check("R9 flush single cycle", flush_o, 0);
    endtask

    task automatic send(input logic [7:0] b, input bit ea, input bit ep, input int ph);
        @(negedge clk) begin rx_valid = 1'b1; rx_data = b; end
        #1;
        check("R3 answer route", atr_route_o, ea);
        check("R4 R5 pps route", pps_route_o, ep);
        @(posedge clk); #1;
        rx_valid = 1'b0;
        check("R4 phase after byte", phase_o, ph);
    endtask

    task automatic strobe(input int which, input logic [7:0] v);
        @(negedge clk);
        case (which)
            0: atr_done = 1'b1;
            1: pps_done = 1'b1;
            2: begin wi_upd = 1'b1; wi_in = v; end
            default: begin fidi_upd = 1'b1; fidi_in = v; end
        endcase
        @(posedge clk); #1;
        atr_done = 1'b0; pps_done = 1'b0; wi_upd = 1'b0; fidi_upd = 1'b0;
    endtask

    task automatic measure(input string tag, input int exp);
        int n = 0;
        do begin
            @(posedge clk); #1;
            n++;
        end while (!flush_o && n < 20000);
        check(tag, n, exp);
        check("R8 return to wait-for-command", phase_o, 3);
    endtask

    task automatic summary();
        if (!ended) begin
            ended = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    endtask

    initial begin
        #(150000 * 5);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        @(posedge clk); #1;
        check("R1 reset phase", phase_o, 0);
        check("R1 reset flush", flush_o, 0);
        check("R10 reset counters", rst_events_o + pps_events_o, 0);

        // R1: line low, bytes and updates ignored
        send(8'hFF, 0, 0, 0);
        send(8'h3B, 0, 0, 0);
        strobe(2, 8'h55);
        check("R1 wi untouched in reset", wi_o, 10);
        strobe(3, 8'h96);
        check("R1 di untouched in reset", di_idx_o, 1);
        repeat (20) @(posedge clk);
        #1 check("R1 phase still reset", phase_o, 0);

        // R2: release
        line(1'b1, 0, 1);
        check("R2 fi", fi_idx_o, 1);
        check("R2 di", di_idx_o, 1);
        check("R2 wi", wi_o, 10);
        check("R2 limit", wt_limit_o, 9600);
        check("R2 reset events", rst_events_o, 1);
        measure("R8 initial expiry ticks", 9600);
        @(posedge clk); #1 check("R8 one pulse", flush_o, 0);

        send(8'h00, 0, 0, 4);
        send(8'h12, 0, 0, 4);
        line(1'b0, 4, 0);

        // full session
        line(1'b1, 0, 1);
        send(8'h3B, 1, 0, 2);
        send(8'h00, 1, 0, 2);
        strobe(2, 8'd1);
        check("R7 wi load", wi_o, 1);
        strobe(3, 8'h11);
        check("R7 fi load", fi_idx_o, 1);
        check("R7 di load", di_idx_o, 1);
        strobe(0, 8'h00);
        check("R6 phase after answer", phase_o, 3);
        check("R6 limit", wt_limit_o, 960);
        send(8'hFF, 0, 1, 5);
        check("R4 pps count", pps_events_o, 1);
        send(8'h10, 0, 1, 5);
        strobe(1, 8'h00);
        check("R5 pps done", phase_o, 3);
        send(8'h20, 0, 0, 4);
        measure("R8 expiry in command", 960);
        begin
            int extra = 0;
            repeat (1200) begin
                @(posedge clk); #1;
                if (flush_o) extra++;
            end
            check("R8 no repeat expiry", extra, 0);
        end
        send(8'h20, 0, 0, 4);
        repeat (500) @(posedge clk);
        send(8'h21, 0, 0, 4);
        measure("R8 byte restarts count", 960);
        send(8'hFF, 0, 1, 5);
        measure("R8 expiry in pps", 960);
        for (int k = 0; k < 8; k++) begin
            send(8'hFF, 0, 1, 5);
            strobe(1, 8'h00);
        end
        check("R10 pps saturation", pps_events_o, 7);

        // R6 sweep of di index against wi
        for (int di = 0; di < 16; di++) begin
            for (int s = 0; s < 3; s++) begin
                int w;
                w = (s == 0) ? 1 : (s == 1) ? 2 : 255;
                line(1'b0, phase_o, 0);
                line(1'b1, 0, 1);
                send(8'h3B, 1, 0, 2);
                strobe(3, 8'(8'h90 | di));
                strobe(2, 8'(w));
                strobe(0, 8'h00);
                check("R6 sweep limit", wt_limit_o, 960 * d_exp(di) * w);
                check("R7 sweep fi", fi_idx_o, 9);
                check("R7 sweep di", di_idx_o, di);
            end
        end
        check("R10 reset event saturation", rst_events_o, 7);
        summary();
    end
endmodule